// File: doc/BRIEF.md
# SPI FIFO Status, Interrupt and DMA-Request Unit

This unit sits between a register bus and a serial shift engine. It holds two word FIFOs. The transmit FIFO is filled by the bus and drained by the engine. The receive FIFO is filled by the engine and drained by the bus. Both FIFOs are read in show-ahead fashion: the head word is on the read-data port during the cycle the pop strobe is high. From the two fill levels the unit derives a status word and a raw interrupt vector, masks the vector, and drives one interrupt line. Two DMA request strobes compare the fill levels with programmable watermarks.

The overflow and underflow conditions are kept as sticky error bits. A write-one clear word removes them, either one at a time or all together. A global enable gates all FIFO traffic, and holding it low empties both FIFOs. The serial engine and the bus decoding sit outside this unit. They only see the strobe and data ports.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset both levels are 0. The status word is 5'b01100 and the raw interrupt vector is 5'b00001. The interrupt line is low.
- R2: Each FIFO returns words in the order they were accepted. Its level rises by one per accepted push and falls by one per accepted pop, and stays the same when both happen in one cycle. A pop of an empty FIFO returns zero on the read-data port.
- R3: The status bits are: bit0 busy (enable high and the TX FIFO not empty), bit1 TX level equal to the depth, bit2 TX level zero, bit3 RX level zero, bit4 RX level equal to the depth.
- R4: A TX push while the TX FIFO is full is dropped. It sets sticky raw interrupt bit1.
- R5: An RX pop while the RX FIFO is empty returns zero. It sets sticky raw interrupt bit2.
- R6: An RX push while the RX FIFO is full is dropped. It sets sticky raw interrupt bit3.
- R7: Raw interrupt bit4 is high exactly when the RX level is strictly greater than the RX threshold.
- R8: Raw interrupt bit0 is high exactly when the TX FIFO is empty.
- R9: A clear-word bit that is high for a cycle clears sticky bits: bit0 clears all three, bit1 clears RX underflow, bit2 clears RX overflow and bit3 clears TX overflow. If a bit is set and cleared in the same cycle, it ends up set.
- R10: The masked vector is the raw vector ANDed with the mask. The interrupt line is the OR of the masked vector, delayed by one register.
- R11: The RX DMA request (enable bit0) is high when the RX level is at least the RX DMA watermark plus one. The TX DMA request (enable bit1) is high when the TX level is at or below the TX DMA watermark. Both requests are low while their enable bit or the global enable is low.
- R12: While the global enable is low, both FIFOs are emptied on every clock. All push and pop strobes are ignored and set no error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global enable; low flushes both FIFOs |
| tx_push | input | 1 | Bus writes a word into the TX FIFO |
| tx_wdata | input | DATA_W | Word written into the TX FIFO |
| tx_pop | input | 1 | Engine takes the TX head word |
| tx_rdata | output | DATA_W | TX head word (zero when empty) |
| rx_push | input | 1 | Engine writes a received word |
| rx_wdata | input | DATA_W | Received word from the engine |
| rx_pop | input | 1 | Bus takes the RX head word |
| rx_rdata | output | DATA_W | RX head word (zero when empty) |
| rx_thresh | input | clog2(DEPTH+1) | RX level threshold for raw bit4 |
| rx_dma_lvl | input | clog2(DEPTH+1) | RX DMA watermark |
| tx_dma_lvl | input | clog2(DEPTH+1) | TX DMA watermark |
| int_mask | input | 5 | Interrupt mask, one bit per raw bit |
| clr_word | input | 4 | Write-one clear strobes for sticky bits |
| dma_en | input | 2 | bit0 RX request enable, bit1 TX request enable |
| tx_level | output | clog2(DEPTH+1) | TX fill level |
| rx_level | output | clog2(DEPTH+1) | RX fill level |
| status | output | 5 | Status word |
| irq_raw | output | 5 | Raw interrupt vector |
| irq_masked | output | 5 | Masked interrupt vector |
| irq | output | 1 | Registered interrupt line |
| rx_dma_req | output | 1 | RX DMA request |
| tx_dma_req | output | 1 | TX DMA request |

## Verification
The bench fills both FIFOs to the exact depth and then pushes one more word. A design that accepted the extra word would show it in the drained sequence or report a level above the depth. It pops the empty RX FIFO and expects zero. A design that returned stale memory or missed the underflow flag fails that check. The bench sweeps the RX threshold and the DMA watermarks across their off-by-one edges, and it sets and clears a sticky bit in the same cycle to catch a design that lets the clear win. It also drops the global enable with words still queued. A design that kept the old words, or counted strobes while disabled, would show a nonzero level or a stale word after the unit is enabled again.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    localparam int STAT_W = 5;
    localparam int IRQ_W  = 5;
    localparam int CLR_W  = 4;
    localparam int DMAE_W = 2;

    // clear-word bit positions
    localparam int CLR_ALL   = 0;
    localparam int CLR_RXUDF = 1;
    localparam int CLR_RXOVF = 2;
    localparam int CLR_TXOVF = 3;

    // DMA enable bit positions
    localparam int DMAE_RX = 0;
    localparam int DMAE_TX = 1;

    // packed MSB first: bit0 is the last field
    typedef struct packed {
        logic rx_full;
        logic rx_empty;
        logic tx_empty;
        logic tx_full;
        logic busy;
    } stat_t;

    typedef struct packed {
        logic rx_above;
        logic rx_ovf;
        logic rx_udf;
        logic tx_ovf;
        logic tx_empty;
    } irq_t;

    function automatic logic sticky_next(logic cur, logic set, logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
    parameter int W     = 16,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] count;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == LW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push & ~full & ~flush;
    assign do_pop  = pop & ~empty & ~flush;
    assign level   = count;
    assign rdata   = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // R2: level moves by at most one word per cycle
    p_level_step_r2: assert property (@(posedge clk) disable iff (rst)
        !flush |=> ((level <= $past(level) + 1) && (level + 1 >= $past(level))));

    // R4/R6: a push into a full buffer without a pop leaves it full
    p_full_push_dropped_r4: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> full);

endmodule

// File: rtl/spi_irq_core.sv
module spi_irq_core
    import spi_fifo_pkg::*;
#(
    parameter int LW = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_empty,
    input  logic             tx_ovf_evt,
    input  logic             rx_udf_evt,
    input  logic             rx_ovf_evt,
    input  logic [LW-1:0]    rx_level,
    input  logic [LW-1:0]    rx_thresh,
    input  logic [IRQ_W-1:0] mask,
    input  logic [CLR_W-1:0] clr,
    output irq_t             raw,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);

    logic tx_ovf_q, rx_udf_q, rx_ovf_q;
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ovf_q <= 1'b0;
            rx_udf_q <= 1'b0;
            rx_ovf_q <= 1'b0;
        end else begin
            tx_ovf_q <= sticky_next(tx_ovf_q, tx_ovf_evt, clr[CLR_ALL] | clr[CLR_TXOVF]);
            rx_udf_q <= sticky_next(rx_udf_q, rx_udf_evt, clr[CLR_ALL] | clr[CLR_RXUDF]);
            rx_ovf_q <= sticky_next(rx_ovf_q, rx_ovf_evt, clr[CLR_ALL] | clr[CLR_RXOVF]);
        end
    end

    always_comb begin
        raw          = '0;
        raw.tx_empty = tx_empty;
        raw.tx_ovf   = tx_ovf_q;
        raw.rx_udf   = rx_udf_q;
        raw.rx_ovf   = rx_ovf_q;
        raw.rx_above = (rx_level > rx_thresh);
    end

    assign masked = raw & mask;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |masked;
    end

    assign irq = irq_q;

    // R10: the line can only be high if some mask bit was set a cycle earlier
    p_irq_needs_mask_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(|mask));

    // R9: a set event beats a simultaneous clear
    p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (rst)
        rx_udf_evt |=> raw.rx_udf);

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
    import spi_fifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enable,
    input  logic                       tx_push,
    input  logic [DATA_W-1:0]          tx_wdata,
    input  logic                       tx_pop,
    output logic [DATA_W-1:0]          tx_rdata,
    input  logic                       rx_push,
    input  logic [DATA_W-1:0]          rx_wdata,
    input  logic                       rx_pop,
    output logic [DATA_W-1:0]          rx_rdata,
    input  logic [$clog2(DEPTH+1)-1:0] rx_thresh,
    input  logic [$clog2(DEPTH+1)-1:0] rx_dma_lvl,
    input  logic [$clog2(DEPTH+1)-1:0] tx_dma_lvl,
    input  logic [4:0]                 int_mask,
    input  logic [3:0]                 clr_word,
    input  logic [1:0]                 dma_en,
    output logic [$clog2(DEPTH+1)-1:0] tx_level,
    output logic [$clog2(DEPTH+1)-1:0] rx_level,
    output logic [4:0]                 status,
    output logic [4:0]                 irq_raw,
    output logic [4:0]                 irq_masked,
    output logic                       irq,
    output logic                       rx_dma_req,
    output logic                       tx_dma_req
);

    localparam int LW = $clog2(DEPTH + 1);

    logic  tx_full, tx_empty, rx_full, rx_empty;
    logic  tx_push_g, tx_pop_g, rx_push_g, rx_pop_g;
    logic  tx_ovf_evt, rx_ovf_evt, rx_udf_evt;
    stat_t stat_s;
    irq_t  raw_s;

    assign tx_push_g = enable & tx_push;
    assign tx_pop_g  = enable & tx_pop;
    assign rx_push_g = enable & rx_push;
    assign rx_pop_g  = enable & rx_pop;

    spi_fifo_buf #(.W(DATA_W), .DEPTH(DEPTH)) u_txbuf (
        .clk   (clk),
        .rst   (rst),
        .flush (~enable),
        .push  (tx_push_g),
        .wdata (tx_wdata),
        .pop   (tx_pop_g),
        .rdata (tx_rdata),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_fifo_buf #(.W(DATA_W), .DEPTH(DEPTH)) u_rxbuf (
        .clk   (clk),
        .rst   (rst),
        .flush (~enable),
        .push  (rx_push_g),
        .wdata (rx_wdata),
        .pop   (rx_pop_g),
        .rdata (rx_rdata),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign tx_ovf_evt = tx_push_g & tx_full;
    assign rx_ovf_evt = rx_push_g & rx_full;
    assign rx_udf_evt = rx_pop_g & rx_empty;

    spi_irq_core #(.LW(LW)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .tx_empty   (tx_empty),
        .tx_ovf_evt (tx_ovf_evt),
        .rx_udf_evt (rx_udf_evt),
        .rx_ovf_evt (rx_ovf_evt),
        .rx_level   (rx_level),
        .rx_thresh  (rx_thresh),
        .mask       (int_mask),
        .clr        (clr_word),
        .raw        (raw_s),
        .masked     (irq_masked),
        .irq        (irq)
    );

    assign irq_raw = raw_s;

    always_comb begin
        stat_s          = '0;
        stat_s.busy     = enable & ~tx_empty;
        stat_s.tx_full  = tx_full;
        stat_s.tx_empty = tx_empty;
        stat_s.rx_empty = rx_empty;
        stat_s.rx_full  = rx_full;
    end

    assign status = stat_s;

    assign rx_dma_req = enable & dma_en[DMAE_RX] &
                        ({1'b0, rx_level} >= ({1'b0, rx_dma_lvl} + 1'b1));
    assign tx_dma_req = enable & dma_en[DMAE_TX] & (tx_level <= tx_dma_lvl);

    // R4: push to a full TX FIFO raises the TX overflow bit
    p_txovf_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (enable && tx_push && tx_full) |=> irq_raw[1]);

    // R5: pop of an empty RX FIFO raises the RX underflow bit
    p_rxudf_sets_r5: assert property (@(posedge clk) disable iff (rst)
        (enable && rx_pop && rx_empty) |=> irq_raw[2]);

    // R6: push to a full RX FIFO raises the RX overflow bit
    p_rxovf_sets_r6: assert property (@(posedge clk) disable iff (rst)
        (enable && rx_push && rx_full) |=> irq_raw[3]);

    // R12: a disabled cycle leaves both FIFOs empty
    p_flush_r12: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (tx_level == '0 && rx_level == '0));

    // R11: an RX request never stands on an empty FIFO
    p_rxdma_nonempty_r11: assert property (@(posedge clk) disable iff (rst)
        rx_dma_req |-> (rx_level != '0));

endmodule

// File: tb/spi_fifo_irq_unit_tb.sv
`timescale 1ns/1ps
module spi_fifo_irq_unit_tb;

    localparam int W  = 16;
    localparam int D  = 32;
    localparam int LW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b1;
    logic          tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [W-1:0]  tx_wdata = '0, rx_wdata = '0;
    logic [W-1:0]  tx_rdata, rx_rdata;
    logic [LW-1:0] rx_thresh = '0, rx_dma_lvl = '0, tx_dma_lvl = '0;
    logic [4:0]    int_mask = '0;
    logic [3:0]    clr_word = '0;
    logic [1:0]    dma_en = '0;
    logic [LW-1:0] tx_level, rx_level;
    logic [4:0]    status, irq_raw, irq_masked;
    logic          irq, rx_dma_req, tx_dma_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [W-1:0] txq[$];
    logic [W-1:0] rxq[$];

    spi_fifo_irq_unit #(.DATA_W(W), .DEPTH(D)) u_dut (
        .clk(clk), .rst(rst), .enable(enable),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_thresh(rx_thresh), .rx_dma_lvl(rx_dma_lvl), .tx_dma_lvl(tx_dma_lvl),
        .int_mask(int_mask), .clr_word(clr_word), .dma_en(dma_en),
        .tx_level(tx_level), .rx_level(rx_level), .status(status),
        .irq_raw(irq_raw), .irq_masked(irq_masked), .irq(irq),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // monitor: compares popped words against the scoreboard queues
    always @(negedge clk) begin
        #1;
        if (!rst && enable && tx_pop) begin
            if (txq.size() > 0) chk("R2 tx order", 32'(tx_rdata), 32'(txq.pop_front()));
            else                chk("R2 tx empty read", 32'(tx_rdata), 0);
        end
        if (!rst && enable && rx_pop) begin
            if (rxq.size() > 0) chk("R2 rx order", 32'(rx_rdata), 32'(rxq.pop_front()));
            else                chk("R5 rx empty read", 32'(rx_rdata), 0);
        end
    end

    // driver: applies one cycle of strobes and records accepted words
    task automatic op(input logic tp, input logic [W-1:0] td, input logic tq,
                      input logic rp, input logic [W-1:0] rd, input logic rq,
                      input logic [3:0] cw);
        @(negedge clk);
        tx_push = tp; tx_wdata = td; tx_pop = tq;
        rx_push = rp; rx_wdata = rd; rx_pop = rq;
        clr_word = cw;
        if (enable) begin
            if (tp && txq.size() < D) txq.push_back(td);
            if (rp && rxq.size() < D) rxq.push_back(rd);
        end
        @(posedge clk);
        #1;
        tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0; clr_word = '0;
    endtask

    task automatic tx_wr(input logic [W-1:0] d); op(1, d, 0, 0, '0, 0, 4'h0); endtask
    task automatic tx_rd();                      op(0, '0, 1, 0, '0, 0, 4'h0); endtask
    task automatic rx_wr(input logic [W-1:0] d); op(0, '0, 0, 1, d, 0, 4'h0); endtask
    task automatic rx_rd();                      op(0, '0, 0, 0, '0, 1, 4'h0); endtask
    task automatic clr(input logic [3:0] c);     op(0, '0, 0, 0, '0, 0, c);    endtask
    task automatic idle();
        @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog got hung run expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk("R1 tx_level", 32'(tx_level), 0);
        chk("R1 rx_level", 32'(rx_level), 0);
        chk("R1 status", 32'(status), 32'h0C);
        chk("R1 irq_raw", 32'(irq_raw), 32'h01);
        chk("R1 irq", 32'(irq), 0);

        // R2 order and levels, R3 busy/empty
        for (int i = 0; i < 5; i++) tx_wr(16'hA000 + 16'(i));
        chk("R2 tx_level after 5", 32'(tx_level), 5);
        chk("R3 status with tx words", 32'(status), 32'h09);
        op(1, 16'hA005, 1, 0, '0, 0, 4'h0);
        chk("R2 level with push+pop", 32'(tx_level), 5);
        for (int i = 0; i < 5; i++) tx_rd();
        chk("R2 tx_level drained", 32'(tx_level), 0);
        for (int i = 0; i < 3; i++) rx_wr(16'h5100 + 16'(i));
        chk("R2 rx_level after 3", 32'(rx_level), 3);
        for (int i = 0; i < 3; i++) rx_rd();

        // R3 TX full, R4 TX overflow
        for (int i = 0; i < D; i++) tx_wr(16'h7000 + 16'(i));
        chk("R3 tx full status", 32'(status), 32'h0B);
        tx_wr(16'hDEAD);
        chk("R4 tx_level held", 32'(tx_level), D);
        chk("R4 tx overflow bit", 32'(irq_raw[1]), 1);
        for (int i = 0; i < D; i++) tx_rd();
        chk("R4 tx drained", 32'(tx_level), 0);
        clr(4'b1000);
        chk("R9 clear tx overflow", 32'(irq_raw), 32'h01);

        // R5 RX underflow
        rx_rd();
        chk("R5 underflow raw", 32'(irq_raw), 32'h05);

        // R6 RX overflow, R3 RX full, R7 with threshold 0
        for (int i = 0; i < D; i++) rx_wr(16'h3300 + 16'(i));
        chk("R3 rx full status", 32'(status), 32'h14);
        rx_wr(16'hBEEF);
        chk("R6 rx_level held", 32'(rx_level), D);
        chk("R6 raw with overflow", 32'(irq_raw), 32'h1D);
        for (int i = 0; i < D; i++) rx_rd();
        chk("R7 raw after drain", 32'(irq_raw), 32'h0D);

        // R9 individual and global clears, set beats clear
        clr(4'b0010);
        chk("R9 clear underflow only", 32'(irq_raw), 32'h09);
        op(0, '0, 0, 0, '0, 1, 4'b0010);
        chk("R9 set beats clear", 32'(irq_raw), 32'h0D);
        clr(4'b0001);
        chk("R9 clear all", 32'(irq_raw), 32'h01);

        // R7 threshold edge
        rx_thresh = LW'(3);
        for (int i = 0; i < 3; i++) rx_wr(16'h4400 + 16'(i));
        chk("R7 level equal threshold", 32'(irq_raw[4]), 0);
        rx_wr(16'h4403);
        chk("R7 level above threshold", 32'(irq_raw[4]), 1);
        for (int i = 0; i < 4; i++) rx_rd();
        chk("R7 below after drain", 32'(irq_raw), 32'h01);

        // R8 TX empty bit
        tx_wr(16'h0042);
        chk("R8 tx not empty", 32'(irq_raw[0]), 0);
        tx_rd();
        chk("R8 tx empty again", 32'(irq_raw[0]), 1);

        // R10 mask and registered line
        int_mask = 5'b00100;
        idle();
        chk("R10 masked hides tx empty", 32'(irq_masked), 0);
        chk("R10 irq low", 32'(irq), 0);
        rx_rd();
        chk("R10 masked underflow", 32'(irq_masked), 32'h04);
        chk("R10 irq lags one cycle", 32'(irq), 0);
        clr(4'b0001);
        chk("R10 irq rises", 32'(irq), 1);
        chk("R10 masked cleared", 32'(irq_masked), 0);
        idle();
        chk("R10 irq falls", 32'(irq), 0);
        int_mask = '0;

        // R11 DMA watermarks
        dma_en = 2'b11;
        rx_dma_lvl = LW'(1);
        tx_dma_lvl = LW'(2);
        idle();
        chk("R11 tx req at level 0", 32'(tx_dma_req), 1);
        chk("R11 rx req at level 0", 32'(rx_dma_req), 0);
        rx_wr(16'h0001);
        chk("R11 rx req at watermark", 32'(rx_dma_req), 0);
        rx_wr(16'h0002);
        chk("R11 rx req above watermark", 32'(rx_dma_req), 1);
        tx_wr(16'h0011);
        tx_wr(16'h0012);
        chk("R11 tx req at watermark", 32'(tx_dma_req), 1);
        tx_wr(16'h0013);
        chk("R11 tx req above watermark", 32'(tx_dma_req), 0);
        dma_en = 2'b10;
        idle();
        chk("R11 rx req disabled", 32'(rx_dma_req), 0);
        dma_en = 2'b00;

        // R12 disable flushes and ignores strobes
        enable = 1'b0;
        txq.delete();
        rxq.delete();
        idle();
        chk("R12 tx flushed", 32'(tx_level), 0);
        chk("R12 rx flushed", 32'(rx_level), 0);
        chk("R12 status idle", 32'(status), 32'h0C);
        tx_wr(16'h1234);
        rx_rd();
        chk("R12 push ignored", 32'(tx_level), 0);
        chk("R12 no error bits", 32'(irq_raw), 32'h01);
        enable = 1'b1;
        idle();
        chk("R12 still empty", 32'(tx_level), 0);
        tx_wr(16'h5A5A);
        chk("R12 fresh word counted", 32'(tx_level), 1);
        tx_rd();
        idle();

        finish_run();
    end

endmodule